// File: doc/BRIEF.md
# Asynchronous Schedule List Walker

This block walks a circular ring of queue heads held in system memory and hands each one to a downstream transaction unit for control and bulk work. Software loads the address of a queue head into the list base register and then raises the enable command. The walker acknowledges through a status bit at the next micro-frame boundary. From then on, every micro-frame strobe starts a servicing pass. A pass begins at the address in the base register. For each queue head it reaches, the walker emits a one-cycle service pulse carrying that address. It then reads the queue head's horizontal link word through a single-outstanding request/response port and follows the link to the next queue head.

A pass stops for one of four reasons: a micro-frame strobe arrives, the enable command drops, the ring has been walked once with no transaction reported by the downstream unit, or a fetched link is malformed. When a pass stops, the base register is loaded with the address the walk would have serviced next. The following pass therefore resumes where the previous one left off, which shares the bus fairly among the queue heads across micro-frames.

Top module: `async_list_walker`

## Requirements
- R1: `run_sts` resets to 0. It changes only on the clock edge after a cycle in which `uf_tick` is high (or after a deferral, see R2), and it then takes the value of `cmd_en`. While `cmd_en` moves with no strobe, `run_sts` holds.
- R2: If a strobe that calls for a status change arrives while a memory read is outstanding, the change is held back. It takes effect on the first edge at which no read is outstanding, after the response has been accepted.
- R3: `base_q` resets to 0. A write on `base_wr` is accepted only while `cmd_en` and `run_sts` are both 0, and it stores `base_wdata` with bits [4:0] cleared. Any other write leaves `base_q` unchanged.
- R4: When `run_sts` and `cmd_en` are both 1 and the walker is idle, a strobe starts a pass. On the next cycle `svc_pulse` is high and `svc_addr` equals `base_q`.
- R5: After each service pulse the walker issues exactly one read, with `rd_addr` equal to the serviced address. The next queue head is `rd_data[31:5]` with five zero low bits, and it is serviced after the response.
- R6: If a link leads back to the queue head where the pass or the current lap began, and `xact_done` has not been seen during that lap, the pass ends. `base_q` then holds that start address, and there are no further pulses or reads until the next strobe.
- R7: If `xact_done` was seen during a lap, the walker carries on around the ring past the start address.
- R8: A strobe that arrives during a pass ends it at the next service point, after any outstanding read. `base_q` takes the address of the queue head about to be serviced, and a new pass starts from that address on the next cycle. No queue head is skipped or repeated across the boundary.
- R9: Clearing `cmd_en` ends the pass at the next service point. `base_q` takes the address of the next queue head, no further pulses or reads occur, and `run_sts` stays 1 until a strobe.
- R10: A link word is rejected if its type field in bits [2:1] is not 01 (queue head) or its terminate bit 0 is 1. A rejected link sets `type_err`, which stays set until reset, ends the pass, and leaves `base_q` unchanged.
- R11: At most one read is outstanding. `rd_req` is a one-cycle pulse, and no new request is made until `rd_vld` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_en | input | 1 | Schedule enable command |
| run_sts | output | 1 | Schedule running status |
| uf_tick | input | 1 | Micro-frame boundary strobe |
| base_wr | input | 1 | List base write strobe |
| base_wdata | input | 32 | List base write data |
| base_q | output | 32 | List base register |
| rd_req | output | 1 | Link word read request pulse |
| rd_addr | output | 32 | Link word read address |
| rd_vld | input | 1 | Read response valid |
| rd_data | input | 32 | Read response link word |
| svc_pulse | output | 1 | Service-this-queue-head pulse |
| svc_addr | output | 32 | Address of queue head to service |
| xact_done | input | 1 | Downstream reports a serviced transaction |
| type_err | output | 1 | Sticky illegal link flag |

## Verification
The bench builds the block with its default alignment of five address bits (32-byte queue heads) and 32-bit links. Its memory model answers reads after a latency of 1, 3 or 6 cycles. The long latency is what holds a read outstanding across a micro-frame strobe, which makes the deferred status change reachable. A three-entry ring is used to exercise the empty-lap exit and the wrap-around that follows reported work. Two extra entries in the model, one with a wrong type and one with the terminate bit set, cover both rejection paths.

// File: rtl/async_walk_pkg.sv
package async_walk_pkg;

    localparam int LINK_W   = 32;
    localparam int TERM_BIT = 0;
    localparam int TYP_LO   = 1;
    localparam int TYP_HI   = 2;

    typedef enum logic [1:0] {
        TYP_ITD  = 2'b00,
        TYP_QH   = 2'b01,
        TYP_SITD = 2'b10,
        TYP_FSTN = 2'b11
    } link_typ_e;

    typedef enum logic [1:0] {
        W_IDLE = 2'b00,
        W_SVC  = 2'b01,
        W_REQ  = 2'b10,
        W_WAIT = 2'b11
    } walk_st_e;

    typedef struct packed {
        logic              hit;
        logic [LINK_W-1:0] ptr;
    } pass_end_t;

    function automatic logic link_is_qh(input logic [LINK_W-1:0] w);
        link_typ_e t;
        t = link_typ_e'(w[TYP_HI:TYP_LO]);
        return (t == TYP_QH) && !w[TERM_BIT];
    endfunction

endpackage

// File: rtl/async_sts_ctl.sv
module async_sts_ctl (
    input  logic clk,
    input  logic rst,
    input  logic cmd_en,
    input  logic uf_tick,
    input  logic rd_busy,
    output logic run_sts
);
    logic pend_q;
    logic want;

    assign want = (cmd_en != run_sts);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_sts <= 1'b0;
            pend_q  <= 1'b0;
        end else if ((uf_tick && want) || pend_q) begin
            if (rd_busy) begin
                pend_q <= 1'b1;
            end else begin
                run_sts <= cmd_en;
                pend_q  <= 1'b0;
            end
        end
    end

    // R1: status moves only after a strobe or a deferred strobe
    a_r1_sts_on_tick: assert property (@(posedge clk) disable iff (rst)
        (!uf_tick && !pend_q) |=> $stable(run_sts));

    // R2: status never moves while a read is outstanding
    a_r2_sts_hold_busy: assert property (@(posedge clk) disable iff (rst)
        rd_busy |=> $stable(run_sts));

endmodule

// File: rtl/async_base_reg.sv
module async_base_reg
    import async_walk_pkg::*;
#(
    parameter int ALIGN_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [LINK_W-1:0] wr_data,
    input  logic              cmd_en,
    input  logic              run_sts,
    input  pass_end_t         pass_end,
    output logic [LINK_W-1:0] base_q
);
    localparam int PTR_W = LINK_W - ALIGN_W;

    logic open_win;
    logic unused_low;

    assign open_win   = !cmd_en && !run_sts;
    assign unused_low = ^wr_data[ALIGN_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (pass_end.hit) begin
            base_q <= pass_end.ptr;
        end else if (wr_en && open_win) begin
            base_q <= {wr_data[LINK_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
        end
    end

    // R3: writes outside the open window leave the register alone
    a_r3_base_locked: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (cmd_en || run_sts) && !pass_end.hit) |=> $stable(base_q));

    initial begin
        assert (PTR_W > 0);
    end

endmodule

// File: rtl/async_walk_fsm.sv
module async_walk_fsm
    import async_walk_pkg::*;
#(
    parameter int ALIGN_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_en,
    input  logic              run_sts,
    input  logic              uf_tick,
    input  logic              xact_done,
    input  logic [LINK_W-1:0] base_q,
    output logic              rd_req,
    output logic [LINK_W-1:0] rd_addr,
    input  logic              rd_vld,
    input  logic [LINK_W-1:0] rd_data,
    output logic              svc_pulse,
    output logic [LINK_W-1:0] svc_addr,
    output logic              rd_busy,
    output pass_end_t         pass_end,
    output logic              type_err
);
    walk_st_e          st_q;
    logic [LINK_W-1:0] cur_q;
    logic [LINK_W-1:0] start_q;
    logic              work_q;
    logic              frame_end_q;
    logic              restart_q;

    logic [LINK_W-1:0] nxt;
    logic              bad;
    logic              stop;
    logic              work_now;
    logic              lap_done;
    logic              empty_hit;
    logic              go;
    logic              unused_rsv;

    assign nxt        = {rd_data[LINK_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
    assign bad        = !link_is_qh(rd_data);
    assign unused_rsv = ^rd_data[ALIGN_W-1:TYP_HI+1];
    assign stop       = frame_end_q || !cmd_en;
    assign work_now   = work_q || xact_done;
    assign lap_done   = (nxt == start_q);
    assign empty_hit  = (st_q == W_WAIT) && rd_vld && !bad && lap_done && !work_now;
    assign go         = run_sts && cmd_en && (uf_tick || restart_q);

    assign rd_req    = (st_q == W_REQ);
    assign rd_addr   = cur_q;
    assign rd_busy   = (st_q == W_REQ) || (st_q == W_WAIT);
    assign svc_pulse = (st_q == W_SVC) && !stop;
    assign svc_addr  = cur_q;

    always_comb begin
        pass_end.hit = 1'b0;
        pass_end.ptr = cur_q;
        if (st_q == W_SVC && stop) begin
            pass_end.hit = 1'b1;
        end else if (empty_hit) begin
            pass_end.hit = 1'b1;
            pass_end.ptr = nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= W_IDLE;
            cur_q       <= '0;
            start_q     <= '0;
            work_q      <= 1'b0;
            frame_end_q <= 1'b0;
            restart_q   <= 1'b0;
            type_err    <= 1'b0;
        end else begin
            if (st_q != W_IDLE && xact_done) work_q <= 1'b1;
            if (st_q != W_IDLE && uf_tick) frame_end_q <= 1'b1;
            case (st_q)
                W_IDLE: begin
                    if (go) begin
                        cur_q       <= base_q;
                        start_q     <= base_q;
                        work_q      <= 1'b0;
                        frame_end_q <= 1'b0;
                        restart_q   <= 1'b0;
                        st_q        <= W_SVC;
                    end else if (!cmd_en || !run_sts) begin
                        restart_q <= 1'b0;
                    end
                end
                W_SVC: begin
                    if (stop) begin
                        restart_q   <= frame_end_q && cmd_en;
                        frame_end_q <= 1'b0;
                        st_q        <= W_IDLE;
                    end else begin
                        st_q <= W_REQ;
                    end
                end
                W_REQ: begin
                    st_q <= W_WAIT;
                end
                W_WAIT: begin
                    if (rd_vld) begin
                        if (bad) begin
                            type_err    <= 1'b1;
                            frame_end_q <= 1'b0;
                            st_q        <= W_IDLE;
                        end else if (empty_hit) begin
                            frame_end_q <= 1'b0;
                            st_q        <= W_IDLE;
                        end else begin
                            cur_q <= nxt;
                            if (lap_done) work_q <= 1'b0;
                            st_q <= W_SVC;
                        end
                    end
                end
                default: st_q <= W_IDLE;
            endcase
        end
    end

    // R10: the error flag only rises on a returned link word
    a_r10_err_after_resp: assert property (@(posedge clk) disable iff (rst)
        $rose(type_err) |-> $past(rd_vld));

    // R11: a request is never issued on two cycles in a row
    a_r11_single_req: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    // R11: no request while waiting for a response
    a_r11_no_req_waiting: assert property (@(posedge clk) disable iff (rst)
        (rd_busy && !rd_vld && !rd_req) |=> !rd_req);

endmodule

// File: rtl/async_list_walker.sv
module async_list_walker
    import async_walk_pkg::*;
#(
    parameter int ALIGN_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_en,
    output logic              run_sts,
    input  logic              uf_tick,
    input  logic              base_wr,
    input  logic [LINK_W-1:0] base_wdata,
    output logic [LINK_W-1:0] base_q,
    output logic              rd_req,
    output logic [LINK_W-1:0] rd_addr,
    input  logic              rd_vld,
    input  logic [LINK_W-1:0] rd_data,
    output logic              svc_pulse,
    output logic [LINK_W-1:0] svc_addr,
    input  logic              xact_done,
    output logic              type_err
);
    logic      rd_busy;
    pass_end_t pass_end;

    async_sts_ctl u_sts (
        .clk     (clk),
        .rst     (rst),
        .cmd_en  (cmd_en),
        .uf_tick (uf_tick),
        .rd_busy (rd_busy),
        .run_sts (run_sts)
    );

    async_base_reg #(.ALIGN_W(ALIGN_W)) u_base (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (base_wr),
        .wr_data  (base_wdata),
        .cmd_en   (cmd_en),
        .run_sts  (run_sts),
        .pass_end (pass_end),
        .base_q   (base_q)
    );

    async_walk_fsm #(.ALIGN_W(ALIGN_W)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .cmd_en    (cmd_en),
        .run_sts   (run_sts),
        .uf_tick   (uf_tick),
        .xact_done (xact_done),
        .base_q    (base_q),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_vld    (rd_vld),
        .rd_data   (rd_data),
        .svc_pulse (svc_pulse),
        .svc_addr  (svc_addr),
        .rd_busy   (rd_busy),
        .pass_end  (pass_end),
        .type_err  (type_err)
    );

    // R4: a queue head is only handed downstream while the schedule runs
    a_r4_svc_while_running: assert property (@(posedge clk) disable iff (rst)
        svc_pulse |-> (run_sts && cmd_en));

endmodule

// File: tb/async_list_walker_tb.sv
module async_list_walker_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_en = 1'b0;
    logic        run_sts;
    logic        uf_tick = 1'b0;
    logic        base_wr = 1'b0;
    logic [31:0] base_wdata = '0;
    logic [31:0] base_q;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_vld = 1'b0;
    logic [31:0] rd_data = '0;
    logic        svc_pulse;
    logic [31:0] svc_addr;
    logic        xact_done = 1'b0;
    logic        type_err;

    int checks = 0;
    int fails = 0;
    int lat = 1;
    int mem_cnt = 0;
    logic mem_pend = 1'b0;
    logic [31:0] mem_addr = '0;
    int overlap = 0;
    int nreads = 0;
    logic work_mode = 1'b0;
    logic [31:0] log_q [0:511];
    int nlog = 0;

    localparam logic [31:0] WR_IN  [4] = '{32'hDEAD_BEEF, 32'h1234_567F, 32'h0000_0300, 32'h0000_0100};
    localparam logic [31:0] WR_EXP [4] = '{32'hDEAD_BEE0, 32'h1234_5660, 32'h0000_0300, 32'h0000_0100};

    always #2 clk = ~clk;

    async_list_walker u_dut (
        .clk (clk), .rst (rst), .cmd_en (cmd_en), .run_sts (run_sts),
        .uf_tick (uf_tick), .base_wr (base_wr), .base_wdata (base_wdata),
        .base_q (base_q), .rd_req (rd_req), .rd_addr (rd_addr),
        .rd_vld (rd_vld), .rd_data (rd_data), .svc_pulse (svc_pulse),
        .svc_addr (svc_addr), .xact_done (xact_done), .type_err (type_err)
    );

    function automatic logic [31:0] link_of(input logic [31:0] a);
        case (a)
            32'h100: return 32'h0000_0202;
            32'h200: return 32'h0000_0302;
            32'h300: return 32'h0000_0102;
            32'h400: return 32'h0000_0500;
            32'h600: return 32'h0000_0103;
            default: return 32'h0000_0000;
        endcase
    endfunction

    function automatic logic [31:0] succ(input logic [31:0] a);
        case (a)
            32'h100: return 32'h200;
            32'h200: return 32'h300;
            default: return 32'h100;
        endcase
    endfunction

    // memory model and service monitor, both driven away from the active edge
    always @(negedge clk) begin
        rd_vld = 1'b0;
        if (mem_cnt > 0) begin
            mem_cnt = mem_cnt - 1;
            if (mem_cnt == 0) begin
                rd_vld   = 1'b1;
                rd_data  = link_of(mem_addr);
                mem_pend = 1'b0;
            end
        end
        if (rd_req) begin
            if (mem_pend) overlap = overlap + 1;
            mem_pend = 1'b1;
            mem_cnt  = lat;
            mem_addr = rd_addr;
            nreads   = nreads + 1;
        end
        if (svc_pulse && nlog < 512) begin
            log_q[nlog] = svc_addr;
            nlog = nlog + 1;
        end
        xact_done = work_mode && svc_pulse;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk) uf_tick = 1'b1;
        @(negedge clk) uf_tick = 1'b0;
    endtask

    task automatic wr_base(input logic [31:0] v);
        @(negedge clk) begin base_wr = 1'b1; base_wdata = v; end
        @(negedge clk) base_wr = 1'b0;
    endtask

    task automatic wait_req();
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (rd_req) break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks = checks + 1;
        fails = fails + 1;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n0;
        int k;
        int nbad;
        logic [31:0] exp_b;
        idle(3);
        @(negedge clk) rst = 1'b0;
        idle(1);
        chk("R1 reset status", {31'b0, run_sts}, 32'd0);
        chk("R3 reset base", base_q, 32'h0);
        chk("R10 reset error", {31'b0, type_err}, 32'd0);
        chk("R11 reset req", {31'b0, rd_req}, 32'd0);

        // R3: accepted writes with alignment masking
        for (int i = 0; i < 4; i++) begin
            wr_base(WR_IN[i]);
            chk("R3 base write", base_q, WR_EXP[i]);
        end

        // R1: enable command alone does not move status
        @(negedge clk) cmd_en = 1'b1;
        idle(3);
        chk("R1 status waits for strobe", {31'b0, run_sts}, 32'd0);
        wr_base(32'h0000_0AA0);
        chk("R3 write ignored while commanded", base_q, 32'h100);
        tick();
        chk("R1 status follows after strobe", {31'b0, run_sts}, 32'd1);

        // R4/R5/R6: empty ring pass
        lat = 3;
        work_mode = 1'b0;
        n0 = nlog;
        tick();
        chk("R4 first service pulse", {31'b0, svc_pulse}, 32'd1);
        chk("R4 first service address", svc_addr, 32'h100);
        idle(40);
        chk("R6 one lap only", nlog - n0, 32'd3);
        chk("R5 second visit", log_q[n0+1], 32'h200);
        chk("R5 third visit", log_q[n0+2], 32'h300);
        chk("R6 base back at start", base_q, 32'h100);
        idle(30);
        chk("R6 quiet until strobe", nlog - n0, 32'd3);

        // R7/R8: work keeps the walk going, strobe ends and restarts it
        work_mode = 1'b1;
        n0 = nlog;
        tick();
        idle(25);
        chk("R7 pass starts at base", log_q[n0], 32'h100);
        chk("R7 wraps past start", log_q[n0+3], 32'h100);
        @(negedge clk) begin uf_tick = 1'b1; work_mode = 1'b0; end
        @(negedge clk) uf_tick = 1'b0;
        k = nlog;
        idle(40);
        nbad = 0;
        for (int i = n0 + 1; i < nlog; i++)
            if (log_q[i] !== succ(log_q[i-1])) nbad = nbad + 1;
        chk("R8 no skip or repeat", nbad, 32'd0);
        chk("R8 resumed pass ran a lap", {31'b0, (nlog - k >= 3)}, 32'd1);
        chk("R8 base at resumed start", base_q, log_q[nlog-3]);

        // R9: dropping the command stops the walk, status waits for strobe
        work_mode = 1'b1;
        tick();
        idle(10);
        wait_req();
        cmd_en = 1'b0;
        idle(20);
        n0 = nlog;
        idle(10);
        chk("R9 no pulses after disable", nlog - n0, 32'd0);
        chk("R9 status held until strobe", {31'b0, run_sts}, 32'd1);
        exp_b = succ(log_q[nlog-1]);
        chk("R9 base at next queue head", base_q, exp_b);
        wr_base(32'h0000_0AA0);
        chk("R3 write ignored while running", base_q, exp_b);
        tick();
        chk("R1 status falls after strobe", {31'b0, run_sts}, 32'd0);

        // R2: status change deferred behind an outstanding read
        lat = 6;
        @(negedge clk) cmd_en = 1'b1;
        tick();
        tick();
        wait_req();
        cmd_en = 1'b0;
        uf_tick = 1'b1;
        @(negedge clk) uf_tick = 1'b0;
        chk("R2 status held while read open", {31'b0, run_sts}, 32'd1);
        idle(3);
        chk("R2 status still held", {31'b0, run_sts}, 32'd1);
        idle(8);
        chk("R2 status falls after response", {31'b0, run_sts}, 32'd0);
        work_mode = 1'b0;

        // R10: wrong type field
        lat = 1;
        wr_base(32'h400);
        @(negedge clk) cmd_en = 1'b1;
        tick();
        n0 = nlog;
        tick();
        idle(20);
        chk("R10 type error raised", {31'b0, type_err}, 32'd1);
        chk("R10 single visit", nlog - n0, 32'd1);
        chk("R10 base unchanged", base_q, 32'h400);

        // R10: terminate bit set
        @(negedge clk) cmd_en = 1'b0;
        tick();
        wr_base(32'h600);
        @(negedge clk) cmd_en = 1'b1;
        tick();
        n0 = nlog;
        tick();
        idle(20);
        chk("R10 terminated link single visit", nlog - n0, 32'd1);
        chk("R10 terminated link visit addr", log_q[n0], 32'h600);
        chk("R10 base unchanged on terminate", base_q, 32'h600);
        chk("R10 error sticky", {31'b0, type_err}, 32'd1);

        // R11: request discipline over the whole run
        chk("R11 no overlapping requests", overlap, 32'd0);
        chk("R11 reads were issued", {31'b0, (nreads > 10)}, 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule